// File: doc/BRIEF.md
# Crosspoint Switch Control Memory

This block is the digital control section of a crosspoint switch with eight lines and four junctors. A host writes one 4-bit word at a time. The 3-bit word address picks a line, and each data bit picks a junctor. A strobe input qualifies each write. The stored bits form a 32-bit switch-enable vector with one bit per crosspoint. That vector also drives a digital model of the switch fabric, which routes line signals onto junctors and junctor signals back onto lines.

The block runs on a system clock. The strobe, address and data inputs come from a slower host, so they pass through a two-stage synchroniser. The address is captured when the strobe is first seen high. The addressed word then follows the data on every cycle while the strobe stays high, so the value present just before the strobe falls is the one kept. The control inputs are plain level signals. There is no valid/ready handshake and no back-pressure: a write cannot be refused or stalled. An asynchronous master clear overrides any write in progress and empties the whole memory.

Top module: `xpt_switch_ctrl`

## Requirements
- R1: While `mr` is high, `sw_en`, `junc_out` and `line_out` are all zero, whatever the other inputs do.
- R2: Bit `i*4+j` of `sw_en` is the crosspoint between line `i` and junctor `j`. `addr` value `i` selects the word for line `i`, and `din` bit `j` controls junctor `j`. A 1 turns the crosspoint on.
- R3: Inputs are driven at a falling clock edge with `ae` rising. The new word appears on `sw_en` after the third rising clock edge, and not before it.
- R4: While `ae` stays high, the addressed word follows `din`. The value held after `ae` falls is the `din` present in the last sampled cycle with `ae` high. A `din` change made together with the fall of `ae` is not stored.
- R5: A write changes only the addressed word. The other seven words keep their contents.
- R6: Writing 0 to a word turns off every crosspoint of that line.
- R7: Raising `mr` clears all 32 bits at once, without waiting for a clock edge. This holds even while `ae` is high. After `mr` is released with `ae` low, the memory stays zero.
- R8: Any set of crosspoints can be on at the same time, including one line on several junctors and several lines on one junctor.
- R9: `junc_out[j]` is the OR over all lines `i` of `line_in[i]` AND crosspoint (i,j).
- R10: `line_out[i]` is the OR over all junctors `j` of `junc_in[j]` AND crosspoint (i,j).
- R11: While `ae` is low, changes on `addr` and `din` have no effect on `sw_en`.
- R12: The address is taken when `ae` is first seen high. An `addr` change while `ae` stays high does not redirect the write to another word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| mr | input | 1 | Master clear, active high, asynchronous |
| ae | input | 1 | Write strobe, active high |
| addr | input | 3 | Word (line) address |
| din | input | 4 | Junctor enable bits for the addressed word |
| line_in | input | 8 | Digital signals driven onto the lines |
| junc_in | input | 4 | Digital signals driven onto the junctors |
| sw_en | output | 32 | Crosspoint enables, bit i*4+j for line i and junctor j |
| junc_out | output | 4 | Fabric output seen on each junctor |
| line_out | output | 8 | Fabric output seen on each line |

## Verification
The bench targets the edges of the strobe window, in five directed tests:
- A `din` change made together with the fall of `ae` must be dropped, while a change made earlier in the window must be kept. A design that commits on the wrong cycle keeps the wrong value.
- An `addr` change partway through a strobe must not spill data into a second word.
- A master clear raised in the middle of an active strobe must zero the outputs before the next clock edge. A synchronous clear would leave the outputs set until that edge.
- After the clear is released, no write may resume unless the strobe is seen again.
- The fabric is checked against a reference matrix across table and random patterns. A transposed index or a wrong OR direction shows up as a mismatched junctor or line output.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
  localparam int unsigned XPT_LINES_DEF = 8;
  localparam int unsigned XPT_JCT_DEF   = 4;

  typedef enum logic {
    STB_IDLE  = 1'b0,
    STB_TRACK = 1'b1
  } stb_state_e;
endpackage

// File: rtl/xpt_sync.sv
module xpt_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      for (int s = 0; s < int'(STAGES); s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < int'(STAGES); s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/xpt_strobe_ctrl.sv
module xpt_strobe_ctrl
  import xpt_pkg::*;
#(
  parameter int unsigned AW = 3,
  parameter int unsigned DW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ae_s,
  input  logic [AW-1:0] addr_s,
  input  logic [DW-1:0] data_s,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  stb_state_e    state_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state_q <= STB_IDLE;
      addr_q  <= '0;
    end else begin
      case (state_q)
        STB_IDLE: if (ae_s) begin
          state_q <= STB_TRACK;
          addr_q  <= addr_s;
        end
        STB_TRACK: if (!ae_s) state_q <= STB_IDLE;
        default: state_q <= STB_IDLE;
      endcase
    end
  end

  // Address frozen at the first sampled strobe cycle; data follows every cycle.
  always_comb begin
    wr_en   = ae_s;
    wr_addr = (state_q == STB_TRACK) ? addr_q : addr_s;
    wr_data = data_s;
  end

  // R12: target word does not move during one strobe window
  p_addr_frozen_r12: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr)));
endmodule

// File: rtl/xpt_ctrl_mem.sv
module xpt_ctrl_mem #(
  parameter int unsigned LINES = 8,
  parameter int unsigned JCT   = 4,
  localparam int unsigned AW   = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int unsigned NBIT = LINES * JCT
) (
  input  logic            clk,
  input  logic            mr,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [JCT-1:0]  wr_data,
  output logic [NBIT-1:0] sw_en
);
  logic [LINES-1:0] sel;
  logic [JCT-1:0]   row_q [LINES];

  for (genvar i = 0; i < int'(LINES); i++) begin : g_row
    assign sel[i] = (wr_addr == AW'(i));

    always_ff @(posedge clk or posedge mr) begin
      if (mr)                  row_q[i] <= '0;
      else if (wr_en && sel[i]) row_q[i] <= wr_data;
    end

    assign sw_en[i*JCT +: JCT] = row_q[i];

    // R5: an unselected row keeps its contents
    p_row_hold_r5: assert property (@(posedge clk) disable iff (mr)
      !(wr_en && sel[i]) |=> $stable(row_q[i]));
    // R3: a selected row loads the presented data
    p_row_load_r3: assert property (@(posedge clk) disable iff (mr)
      (wr_en && sel[i]) |=> (row_q[i] == $past(wr_data)));
  end

  // R2: the decoder never selects more than one word
  always_comb begin
    p_sel_onehot_r2: assert ($onehot0(sel));
  end

  // R7: memory held at zero while the clear is high
  p_clear_hold_r7: assert property (@(negedge clk) mr |-> (sw_en == '0));
endmodule

// File: rtl/xpt_fabric.sv
module xpt_fabric #(
  parameter int unsigned LINES = 8,
  parameter int unsigned JCT   = 4,
  localparam int unsigned NBIT = LINES * JCT
) (
  input  logic [NBIT-1:0]  sw_en,
  input  logic [LINES-1:0] line_in,
  input  logic [JCT-1:0]   junc_in,
  output logic [JCT-1:0]   junc_out,
  output logic [LINES-1:0] line_out
);
  always_comb begin
    junc_out = '0;
    line_out = '0;
    for (int i = 0; i < int'(LINES); i++) begin
      for (int j = 0; j < int'(JCT); j++) begin
        if (sw_en[i*JCT + j]) begin
          junc_out[j] = junc_out[j] | line_in[i];
          line_out[i] = line_out[i] | junc_in[j];
        end
      end
    end
    // R9/R10: with no crosspoint on, every line is isolated from every junctor
    if (sw_en == '0) begin
      p_isolated_r9: assert ((junc_out == '0) && (line_out == '0));
    end
  end
endmodule

// File: rtl/xpt_switch_ctrl.sv
module xpt_switch_ctrl
  import xpt_pkg::*;
#(
  parameter int unsigned LINES = XPT_LINES_DEF,
  parameter int unsigned JCT   = XPT_JCT_DEF,
  localparam int unsigned AW   = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int unsigned NBIT = LINES * JCT,
  localparam int unsigned SW   = 1 + AW + JCT
) (
  input  logic             clk,
  input  logic             mr,
  input  logic             ae,
  input  logic [AW-1:0]    addr,
  input  logic [JCT-1:0]   din,
  input  logic [LINES-1:0] line_in,
  input  logic [JCT-1:0]   junc_in,
  output logic [NBIT-1:0]  sw_en,
  output logic [JCT-1:0]   junc_out,
  output logic [LINES-1:0] line_out
);
  logic          ae_s;
  logic [AW-1:0] addr_s;
  logic [JCT-1:0] din_s;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [JCT-1:0] wr_data;

  xpt_sync #(.WIDTH(SW), .STAGES(2)) u_sync (
    .clk (clk),
    .rst (mr),
    .d   ({ae, addr, din}),
    .q   ({ae_s, addr_s, din_s})
  );

  xpt_strobe_ctrl #(.AW(AW), .DW(JCT)) u_stb (
    .clk     (clk),
    .rst     (mr),
    .ae_s    (ae_s),
    .addr_s  (addr_s),
    .data_s  (din_s),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
  );

  xpt_ctrl_mem #(.LINES(LINES), .JCT(JCT)) u_mem (
    .clk     (clk),
    .mr      (mr),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .sw_en   (sw_en)
  );

  xpt_fabric #(.LINES(LINES), .JCT(JCT)) u_fab (
    .sw_en    (sw_en),
    .line_in  (line_in),
    .junc_in  (junc_in),
    .junc_out (junc_out),
    .line_out (line_out)
  );

  // R11: memory does not change unless the synchronised strobe is high
  p_idle_stable_r11: assert property (@(posedge clk) disable iff (mr)
    !ae_s |=> $stable(sw_en));
endmodule

// File: tb/xpt_switch_ctrl_tb.sv
module xpt_switch_ctrl_tb;
  logic        clk = 1'b0;
  logic        mr;
  logic        ae;
  logic [2:0]  addr;
  logic [3:0]  din;
  logic [7:0]  line_in;
  logic [3:0]  junc_in;
  logic [31:0] sw_en;
  logic [3:0]  junc_out;
  logic [7:0]  line_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic [3:0] ref_mem [8];

  always #5 clk = ~clk;

  xpt_switch_ctrl u_dut (
    .clk(clk), .mr(mr), .ae(ae), .addr(addr), .din(din),
    .line_in(line_in), .junc_in(junc_in),
    .sw_en(sw_en), .junc_out(junc_out), .line_out(line_out)
  );

  typedef struct packed {
    logic [2:0] a;
    logic [3:0] d;
    logic [7:0] l;
    logic [3:0] j;
  } vec_t;

  localparam vec_t TABLE [10] = '{
    '{3'd0, 4'h1, 8'h01, 4'h1},
    '{3'd7, 4'h8, 8'h80, 4'h8},
    '{3'd3, 4'hF, 8'h08, 4'h0},
    '{3'd5, 4'h6, 8'hFF, 4'hF},
    '{3'd1, 4'h1, 8'h02, 4'h2},
    '{3'd2, 4'h1, 8'h06, 4'h1},
    '{3'd3, 4'h0, 8'h08, 4'hF},
    '{3'd6, 4'hA, 8'h40, 4'h5},
    '{3'd4, 4'h5, 8'h10, 4'hA},
    '{3'd0, 4'h0, 8'hAA, 4'h3}
  };

  function automatic logic [31:0] ref_sw();
    logic [31:0] r;
    for (int i = 0; i < 8; i++) r[i*4 +: 4] = ref_mem[i];
    return r;
  endfunction

  function automatic logic [3:0] ref_junc(input logic [7:0] li);
    logic [3:0] r = '0;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 4; j++)
        if (li[i] && ref_mem[i][j]) r[j] = 1'b1;
    return r;
  endfunction

  function automatic logic [7:0] ref_line(input logic [3:0] ji);
    logic [7:0] r = '0;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 4; j++)
        if (ji[j] && ref_mem[i][j]) r[i] = 1'b1;
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] a, input logic [3:0] d);
    @(negedge clk);
    addr = a; din = d; ae = 1'b1;
    repeat (3) @(negedge clk);
    ae = 1'b0;
    repeat (3) @(negedge clk);
    ref_mem[a] = d;
  endtask

  task automatic chk_fabric(input string req, input logic [7:0] li, input logic [3:0] ji);
    line_in = li; junc_in = ji;
    #1;
    chk({req, " junc_out R9"}, 32'(junc_out), 32'(ref_junc(li)));
    chk({req, " line_out R10"}, 32'(line_out), 32'(ref_line(ji)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) ref_mem[i] = '0;
    mr = 1'b1; ae = 1'b0; addr = '0; din = '0; line_in = '1; junc_in = '1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 sw_en in reset", sw_en, 32'h0);
    chk("R1 junc_out in reset", 32'(junc_out), 32'h0);
    chk("R1 line_out in reset", 32'(line_out), 32'h0);
    mr = 1'b0;
    line_in = '0; junc_in = '0;

    // R2 R5 R6 R8 R9 R10: table walk against reference matrix
    for (int k = 0; k < 10; k++) begin
      do_write(TABLE[k].a, TABLE[k].d);
      chk("R2 R5 R6 R8 table sw_en", sw_en, ref_sw());
      chk_fabric("table", TABLE[k].l, TABLE[k].j);
    end

    // R3: latency of three rising edges
    @(negedge clk);
    addr = 3'd2; din = 4'hE; ae = 1'b1;
    @(negedge clk); chk("R3 edge1 unchanged", 32'(sw_en[11:8]), 32'(ref_mem[2]));
    @(negedge clk); chk("R3 edge2 unchanged", 32'(sw_en[11:8]), 32'(ref_mem[2]));
    @(negedge clk); chk("R3 edge3 written", 32'(sw_en[11:8]), 32'hE);
    ae = 1'b0;
    repeat (3) @(negedge clk);
    ref_mem[2] = 4'hE;
    chk("R3 R5 full vector", sw_en, ref_sw());

    // R4: last data before strobe fall; change coincident with fall dropped
    addr = 3'd1; din = 4'h3; ae = 1'b1;
    repeat (4) @(negedge clk);
    din = 4'hC;
    repeat (4) @(negedge clk);
    ae = 1'b0; din = 4'h5;
    repeat (4) @(negedge clk);
    ref_mem[1] = 4'hC;
    chk("R4 retained value", 32'(sw_en[7:4]), 32'hC);

    // R11: addr/din wiggle with strobe low
    for (int k = 0; k < 6; k++) begin
      addr = 3'(k); din = 4'(k * 3 + 1);
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    chk("R11 idle inputs ignored", sw_en, ref_sw());

    // R12: address change mid-strobe does not redirect
    addr = 3'd6; din = 4'h9; ae = 1'b1;
    repeat (4) @(negedge clk);
    addr = 3'd7;
    repeat (4) @(negedge clk);
    ae = 1'b0;
    repeat (4) @(negedge clk);
    ref_mem[6] = 4'h9;
    chk("R12 address frozen", sw_en, ref_sw());

    // R7: async clear during active strobe
    addr = 3'd5; din = 4'hF; ae = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7 pre-clear written", 32'(sw_en[23:20]), 32'hF);
    #2 mr = 1'b1;
    #1 chk("R7 immediate clear", sw_en, 32'h0);
    for (int i = 0; i < 8; i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    chk("R7 held with strobe high", sw_en, 32'h0);
    chk_fabric("R7 isolated", 8'hFF, 4'hF);
    ae = 1'b0;
    @(negedge clk);
    mr = 1'b0;
    repeat (5) @(negedge clk);
    chk("R7 stays clear after release", sw_en, 32'h0);

    // R8 R9 R10: random patterns
    for (int k = 0; k < 20; k++) begin
      do_write(3'($urandom_range(0, 7)), 4'($urandom_range(0, 15)));
      chk("R8 random sw_en", sw_en, ref_sw());
      chk_fabric("random", 8'($urandom_range(0, 255)), 4'($urandom_range(0, 15)));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule